// File: doc/BRIEF.md
# COBS Stream Decoder

This block turns a received byte stream framed with Consistent Overhead Byte Stuffing back into raw payload bytes. It sits behind a UART receiver, accepts one byte per valid strobe, and writes each decoded payload byte into a buffer. The write address is a base offset, supplied by the consumer, plus the running position within the frame.

A zero byte always closes a frame. The block then pulses an end-of-packet strobe carrying the number of payload positions filled. This happens even when the frame was empty, or when its content was garbage because the block had not yet synchronised. The higher protocol layer is expected to judge the frame by its length.

A receiver overrun indication drops the frame in progress. The decoder then waits for the next zero byte before it trusts the stream again.

All outputs are registered and appear one clock after the input byte is sampled. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `cobs_stream_decoder`

## Requirements
- R1: After reset, no write, end-of-packet or error output is active, and the decoder is in the wait-for-sync state.
- R2: A zero byte in any state (with no overrun) gives, one cycle later, `eop_vld_o`=1 with `eop_len_o` equal to the number of payload bytes written in the frame. It clears the position and moves to the wait-for-overhead state.
- R3: In the wait-for-sync state, non-zero bytes produce no write and no end-of-packet.
- R4: In the wait-for-overhead state, a non-zero byte is not written. It loads the skip counter and moves to the running state.
- R5: In the running state, a byte whose decremented skip count is not zero is written unchanged, at address `base_ofs_i` + position. The position then advances by one.
- R6: In the running state, a byte whose decremented skip count reaches zero is written as 0x00, and its own value reloads the skip counter.
- R7: With `ovr_i`=1, the byte input of that cycle is ignored. One cycle later `err_o` pulses for exactly one cycle with no write and no end-of-packet. The position is cleared and the decoder returns to wait-for-sync.
- R8: The position saturates at 254. Payload bytes beyond the 254th in a frame are not written, and the frame reports length 254.
- R9: The encoded stream 00 03 11 22 02 33 00 writes 11 22 00 33 to offsets 0..3 and reports length 4.
- R10: A zero byte that arrives directly after the zero that opened a frame reports length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | Received byte valid |
| byte_dat_i | input | 8 | Received byte |
| ovr_i | input | 1 | Receiver overrun indication |
| base_ofs_i | input | AW (10) | Buffer base offset for the current frame |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | AW (10) | Buffer write address |
| wr_data_o | output | 8 | Decoded payload byte |
| eop_vld_o | output | 1 | End-of-packet strobe |
| eop_len_o | output | 8 | Payload length of the closed frame |
| err_o | output | 1 | One-cycle overrun error pulse |

## Verification
The assertions check the state transitions on every cycle:
- a zero byte leads to wait-for-overhead;
- an overrun leads to wait-for-sync and an error pulse;
- a non-zero overhead byte leads to running;
- no write occurs while unsynchronised;
- the position never passes its cap;
- writes and end-of-packet never coincide.

The bench alone can show that the decoded values are right. It covers the zero substitution when the skip count expires, the addresses and reported lengths, saturation on an overlong frame, and the reference sequence. It compares each output against a behavioural model over random streams that mix zeros, overruns and idle cycles.

// File: rtl/cobs_dec_pkg.sv
package cobs_dec_pkg;
  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_OVH  = 2'd1,
    ST_RUN  = 2'd2
  } dec_state_e;
endpackage

// File: rtl/cobs_dec_fsm.sv
module cobs_dec_fsm
  import cobs_dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_dat,
  input  logic          in_ovr,
  output dec_state_e    st_o,
  output logic          pay_vld_o,
  output logic [DW-1:0] pay_dat_o,
  output logic          eop_o
);
  dec_state_e    st_q, st_n;
  logic [DW-1:0] skip_q, skip_n, skip_dec;
  logic          adv;

  assign adv      = in_ovr | in_vld;
  assign skip_dec = skip_q - 1'b1;

  always_comb begin
    st_n      = st_q;
    skip_n    = skip_q;
    pay_vld_o = 1'b0;
    pay_dat_o = in_dat;
    eop_o     = 1'b0;
    if (in_ovr) begin
      st_n = ST_SYNC;
    end else if (in_vld) begin
      if (in_dat == '0) begin
        eop_o = 1'b1;
        st_n  = ST_OVH;
      end else begin
        case (st_q)
          ST_OVH: begin
            skip_n = in_dat;
            st_n   = ST_RUN;
          end
          ST_RUN: begin
            pay_vld_o = 1'b1;
            if (skip_dec == '0) begin
              pay_dat_o = '0;
              skip_n    = in_dat;
            end else begin
              skip_n = skip_dec;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SYNC;
      skip_q <= '0;
    end else if (adv) begin
      st_q   <= st_n;
      skip_q <= skip_n;
    end
  end

  assign st_o = st_q;

  // R2: a clean zero byte always lands in wait-for-overhead
  a_r2_zero_to_ovh: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_ovr && in_dat == '0) |=> st_q == ST_OVH);
  // R4: a non-zero overhead byte starts the running state
  a_r4_ovh_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OVH && in_vld && !in_ovr && in_dat != '0) |=> st_q == ST_RUN);
  // R7: overrun forces resynchronisation
  a_r7_ovr_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
    in_ovr |=> st_q == ST_SYNC);
endmodule

// File: rtl/cobs_dec_pos.sv
module cobs_dec_pos #(
  parameter int MAX_LEN = 254,
  parameter int PW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [PW-1:0] pos_o,
  output logic          room_o
);
  localparam logic [PW-1:0] CAP = PW'(MAX_LEN);

  logic [PW-1:0] pos_q, pos_n;
  logic          upd;

  assign room_o = (pos_q < CAP);
  assign upd    = clr | (inc & room_o);

  always_comb begin
    if (clr) pos_n = '0;
    else     pos_n = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos_q <= '0;
    else if (upd) pos_q <= pos_n;
  end

  assign pos_o = pos_q;

  // R8: position never passes the frame-length cap
  a_r8_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= CAP);
  // R2: clearing resets the position on the next cycle
  a_r2_pos_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pos_q == '0);
endmodule

// File: rtl/cobs_stream_decoder.sv
module cobs_stream_decoder
  import cobs_dec_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 10,
  parameter int MAX_LEN = 254,
  parameter int PW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_dat_i,
  input  logic          ovr_i,
  input  logic [AW-1:0] base_ofs_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          eop_vld_o,
  output logic [PW-1:0] eop_len_o,
  output logic          err_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  dec_state_e    st;
  logic          pay_vld, eop, room;
  logic [DW-1:0] pay_dat;
  logic [PW-1:0] pos;
  logic          wr_go;
  logic [AW-1:0] addr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  cobs_dec_fsm #(.DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_s_n), .in_vld(byte_vld_i), .in_dat(byte_dat_i),
    .in_ovr(ovr_i), .st_o(st), .pay_vld_o(pay_vld), .pay_dat_o(pay_dat),
    .eop_o(eop)
  );

  cobs_dec_pos #(.MAX_LEN(MAX_LEN), .PW(PW)) pos_i (
    .clk(clk), .rst_n(rst_s_n), .clr(ovr_i | eop), .inc(pay_vld),
    .pos_o(pos), .room_o(room)
  );

  always_comb begin
    wr_go  = pay_vld & room;
    addr_n = base_ofs_i + AW'(pos);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_en_o   <= 1'b0;
      eop_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      wr_en_o   <= wr_go;
      eop_vld_o <= eop;
      err_o     <= ovr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (wr_go) begin
      wr_addr_o <= addr_n;
      wr_data_o <= pay_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)  eop_len_o <= '0;
    else if (eop)  eop_len_o <= pos;
  end

  // R3: no write may follow a byte seen while unsynchronised
  a_r3_sync_discard: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st == ST_SYNC && byte_vld_i && !ovr_i) |=> !wr_en_o);
  // R7: overrun yields a lone error pulse
  a_r7_err_follows_ovr: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovr_i |=> (err_o && !eop_vld_o && !wr_en_o));
  // R2: a frame end never carries a payload write
  a_r2_eop_no_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(eop_vld_o && wr_en_o));
  // R8: reported length stays within the cap
  a_r8_len_cap: assert property (@(posedge clk) disable iff (!rst_s_n)
    eop_vld_o |-> eop_len_o <= PW'(MAX_LEN));
endmodule

// File: tb/cobs_stream_decoder_tb_top.sv
module cobs_stream_decoder_tb_top;
  localparam int AW = 10;
  localparam int MAXL = 254;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          byte_vld_i;
  logic [7:0]    byte_dat_i;
  logic          ovr_i;
  logic [AW-1:0] base_ofs_i;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0]    wr_data_o;
  logic          eop_vld_o;
  logic [7:0]    eop_len_o;
  logic          err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_st, m_cnt, m_pos;
  int cap_n;
  logic [7:0] cap [0:15];
  int last_len;

  always #10 clk = ~clk;

  cobs_stream_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .byte_dat_i(byte_dat_i),
    .ovr_i(ovr_i), .base_ofs_i(base_ofs_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .eop_vld_o(eop_vld_o),
    .eop_len_o(eop_len_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit vld, input logic [7:0] dat, input bit ovr);
    bit e_wr = 0, e_eop = 0, e_err = 0;
    int e_addr = 0, e_data = 0, e_len = 0;
    string tag = "R1";
    @(negedge clk);
    byte_vld_i = vld; byte_dat_i = dat; ovr_i = ovr;
    if (ovr) begin
      e_err = 1; m_pos = 0; m_st = 0; tag = "R7";
    end else if (vld) begin
      if (dat == 8'h00) begin
        e_eop = 1; e_len = m_pos; tag = (m_pos == 0) ? "R10" : "R2";
        m_pos = 0; m_st = 1;
      end else if (m_st == 0) begin
        tag = "R3";
      end else if (m_st == 1) begin
        m_cnt = dat; m_st = 2; tag = "R4";
      end else begin
        int d = dat;
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin d = 0; m_cnt = dat; tag = "R6"; end
        else tag = "R5";
        if (m_pos < MAXL) begin
          e_wr = 1; e_addr = (base_ofs_i + m_pos) % (1 << AW); e_data = d; m_pos++;
        end else tag = "R8";
      end
    end
    @(posedge clk);
    #2;
    chk(wr_en_o == e_wr, tag, "wr_en", wr_en_o, e_wr);
    if (e_wr) begin
      chk(wr_addr_o == e_addr, tag, "wr_addr", wr_addr_o, e_addr);
      chk(wr_data_o == e_data, tag, "wr_data", wr_data_o, e_data);
      if (cap_n < 16) cap[cap_n] = wr_data_o;
      cap_n++;
    end
    chk(eop_vld_o == e_eop, tag, "eop_vld", eop_vld_o, e_eop);
    if (e_eop) begin
      chk(eop_len_o == e_len, tag, "eop_len", eop_len_o, e_len);
      last_len = eop_len_o;
    end
    chk(err_o == e_err, tag, "err", err_o, e_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; byte_vld_i = 0; byte_dat_i = 0; ovr_i = 0; base_ofs_i = '0;
    m_st = 0; m_cnt = 0; m_pos = 0; cap_n = 0; last_len = -1;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs idle while in reset
    chk(!wr_en_o && !eop_vld_o && !err_o, "R1", "reset outputs", {wr_en_o, eop_vld_o, err_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(!wr_en_o && !eop_vld_o && !err_o, "R1", "post-reset outputs", {wr_en_o, eop_vld_o, err_o}, 0);

    // R1/R3: non-zero bytes before first zero are dropped
    step(1, 8'h03, 0); step(1, 8'h11, 0); step(1, 8'h05, 0);

    // R9: reference sequence at base 0
    base_ofs_i = '0;
    step(1, 8'h00, 0);
    cap_n = 0;
    step(1, 8'h03, 0); step(1, 8'h11, 0); step(1, 8'h22, 0);
    step(1, 8'h02, 0); step(1, 8'h33, 0); step(1, 8'h00, 0);
    chk(cap_n == 4 && cap[0] == 8'h11 && cap[1] == 8'h22 && cap[2] == 8'h00 && cap[3] == 8'h33,
        "R9", "decoded bytes", {cap[0], cap[1], cap[2], cap[3]}, 32'h11220033);
    chk(last_len == 4, "R9", "length", last_len, 4);

    // R10: empty frame
    step(1, 8'h00, 0);
    chk(last_len == 0, "R10", "empty length", last_len, 0);

    // R7: overrun mid-frame, then bytes ignored until zero
    base_ofs_i = 10'd100;
    step(1, 8'h02, 0); step(1, 8'h44, 0); step(1, 8'h55, 1);
    step(1, 8'h07, 0); step(1, 8'h08, 0);
    step(1, 8'h00, 0);

    // R8: overlong frame saturates at 254
    base_ofs_i = 10'd500;
    step(1, 8'hFF, 0);
    for (int i = 0; i < 260; i++) step(1, 8'(1 + (i % 200)), 0);
    step(1, 8'h00, 0);
    chk(last_len == MAXL, "R8", "saturated length", last_len, MAXL);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      if (r < 3) step(1, 8'($urandom), 1);
      else if (r < 10) step(0, 8'($urandom), 0);
      else if (r < 28) begin
        base_ofs_i = AW'($urandom);
        step(1, 8'h00, 0);
      end else step(1, 8'(1 + ($urandom % 255)), 0);
    end
    step(0, 8'h00, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule